// File: doc/BRIEF.md
# Masked Register Poll-Wait Comparator

This block carries out two command-processor packet forms that both test a polled location against a reference. The command parser hands over an already-sliced payload in one transfer. That payload holds a 3-bit compare function, a source select, a poll address, a reference, a mask, a retry interval, and for the conditional form a target register address and a data word. The block reads the polled location through a request/response port. It masks the returned value and compares it, unsigned, against the reference.

In the wait form the block keeps polling until the compare succeeds. It holds the command stream the whole time, because it does not accept a new command until it finishes. The retry interval sets the pacing between polls. A short interval means an immediate retry. A longer one makes the block idle for a whole number of prescaler ticks. In the conditional-write form the block polls once. It emits a single register write only if the compare succeeds, and reports the verdict in either case.

Top module: `cpw_poll_wait`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ready` is 1 and `rd_req`, `wr_en` and `done` are 0.
- R2: Function code 0 never matches, code 7 always matches, code 1 matches when (value & mask) < reference and code 6 when (value & mask) > reference. The comparison is unsigned 32-bit.
- R3: Function codes 2, 3, 4 and 5 match on (value & mask) less-or-equal, equal, not-equal and greater-or-equal to the reference, respectively. Bits outside the mask never affect the result.
- R4: Every poll is a one-cycle `rd_req` carrying the accepted poll address on `rd_addr`. `rd_from_mem` is the accepted source select, which is control-word bit 4 (1 = memory, 0 = register file). The function code is control-word bits [2:0].
- R5: In the wait form (`cmd_cond` = 0), the block reads again after every mismatching response. It raises `done` with `done_match` = 1 only after the first matching response, and it never writes.
- R6: In the wait form with an interval below 0x100, the next `rd_req` appears in the cycle right after the mismatching response.
- R7: In the wait form with an interval of 0x100 or more, the block issues no request for (interval >> 8) × TICK_CYCLES cycles after the mismatching response. The request follows in the next cycle.
- R8: In the conditional-write form (`cmd_cond` = 1), exactly one poll is made. On a match `wr_en` pulses for one cycle with the accepted target address and data, in the same cycle as `done` with `done_match` = 1.
- R9: In the conditional-write form, a mismatch gives `done` with `done_match` = 0 and no `wr_en`.
- R10: `cmd_ready` is 1 only while idle. Command inputs that are offered or changed while the block is busy do not alter the command in progress.
- R11: `done` lasts one cycle, and `cmd_ready` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_cond | input | 1 | 1 = conditional write, 0 = wait |
| cmd_func | input | 3 | Compare function code |
| cmd_from_mem | input | 1 | Poll source: 1 memory, 0 register file |
| cmd_poll_addr | input | AW | Polled location |
| cmd_ref | input | DW | Reference value |
| cmd_mask | input | DW | Mask applied to polled value |
| cmd_interval | input | DW | Retry interval (wait form) |
| cmd_wr_addr | input | AW | Target register (conditional form) |
| cmd_wr_data | input | DW | Data to write (conditional form) |
| rd_req | output | 1 | Poll read request, one cycle |
| rd_from_mem | output | 1 | Source of the read |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | DW | Read response data |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | AW | Register write address |
| wr_data | output | DW | Register write data |
| done | output | 1 | Command finished, one cycle |
| done_match | output | 1 | Final compare verdict |

## Verification
In the conditional form, the compare verdict, the write strobe and the completion pulse all come out of the same response cycle. A next command may be offered right after. The bench makes each of these cycles with directed boundary values (equal, masked-off bits, top-bit set) and with random payloads. At the completion cycle it checks that the strobe is present exactly when the verdict is a match, and that the address and data are the originals even though the command inputs were scrambled while the block was busy. It also checks that the block is ready again one cycle later. Pacing is judged by timing the gap from each mismatching response to the next request against the interval.

// File: rtl/cpw_pkg.sv
package cpw_pkg;
  typedef enum logic [2:0] {
    FN_NEVER  = 3'd0,
    FN_LT     = 3'd1,
    FN_LE     = 3'd2,
    FN_EQ     = 3'd3,
    FN_NE     = 3'd4,
    FN_GE     = 3'd5,
    FN_GT     = 3'd6,
    FN_ALWAYS = 3'd7
  } cmp_fn_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_RSP   = 2'd2,
    ST_PAUSE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cpw_compare.sv
module cpw_compare
  import cpw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    fn,
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] cmp_ref,
  output logic          match
);
  function automatic logic masked_test(cmp_fn_e f, logic [DW-1:0] v,
                                       logic [DW-1:0] m, logic [DW-1:0] r);
    logic [DW-1:0] x;
    x = v & m;
    case (f)
      FN_NEVER:  return 1'b0;
      FN_LT:     return x <  r;
      FN_LE:     return x <= r;
      FN_EQ:     return x == r;
      FN_NE:     return x != r;
      FN_GE:     return x >= r;
      FN_GT:     return x >  r;
      default:   return 1'b1;
    endcase
  endfunction

  assign match = masked_test(cmp_fn_e'(fn), value, mask, cmp_ref);
endmodule

// File: rtl/cpw_pacer.sv
module cpw_pacer #(
  parameter int UW          = 24,
  parameter int TICK_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [UW-1:0] units,
  input  logic          active,
  output logic          expire
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] left_q;
  logic          tick;

  assign tick   = active && (pre_q == PRE_LAST);
  assign expire = tick && (left_q == UW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      left_q <= '0;
    end else if (start) begin
      pre_q  <= '0;
      left_q <= units;
    end else if (active) begin
      if (tick) begin
        pre_q  <= '0;
        left_q <= left_q - UW'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  // R7: a pause is only started with a nonzero unit count
  p_units_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (units != '0));
  // R7: the unit counter never runs dry while pausing
  p_left_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left_q != '0));
endmodule

// File: rtl/cpw_seq.sv
module cpw_seq
  import cpw_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 16,
  parameter int IVL_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_cond,
  input  logic [2:0]          cmd_func,
  input  logic                cmd_from_mem,
  input  logic [AW-1:0]       cmd_poll_addr,
  input  logic [DW-1:0]       cmd_ref,
  input  logic [DW-1:0]       cmd_mask,
  input  logic [DW-1:0]       cmd_interval,
  input  logic [AW-1:0]       cmd_wr_addr,
  input  logic [DW-1:0]       cmd_wr_data,
  output logic                rd_req,
  output logic                rd_from_mem,
  output logic [AW-1:0]       rd_addr,
  input  logic                rd_ack,
  input  logic                match,
  output logic [2:0]          cmp_fn,
  output logic [DW-1:0]       cmp_mask,
  output logic [DW-1:0]       cmp_ref,
  output logic                pace_start,
  output logic [DW-IVL_SHIFT-1:0] pace_units,
  output logic                pace_active,
  input  logic                pace_expire,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [DW-1:0]       wr_data,
  output logic                done,
  output logic                done_match
);
  localparam int UW = DW - IVL_SHIFT;
  localparam logic [DW-1:0] LONG_THRESH = DW'(1) << IVL_SHIFT;

  seq_state_e    state_q;
  logic          cond_q;
  logic          mem_q;
  logic [2:0]    fn_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] ref_q;
  logic [DW-1:0] mask_q;
  logic          long_q;
  logic [UW-1:0] units_q;
  logic [AW-1:0] wadr_q;
  logic [DW-1:0] wdat_q;

  // named internal events
  logic accept_evt, ack_evt, poll_hit, poll_miss, retry_now;

  assign accept_evt = (state_q == ST_IDLE) && cmd_valid;
  assign ack_evt    = (state_q == ST_RSP) && rd_ack;
  assign poll_hit   = ack_evt && match;
  assign poll_miss  = ack_evt && !match;
  assign retry_now  = poll_miss && !cond_q && !long_q;

  assign cmd_ready   = (state_q == ST_IDLE);
  assign rd_req      = (state_q == ST_REQ);
  assign rd_from_mem = mem_q;
  assign rd_addr     = addr_q;
  assign cmp_fn      = fn_q;
  assign cmp_mask    = mask_q;
  assign cmp_ref     = ref_q;
  assign pace_start  = poll_miss && !cond_q && long_q;
  assign pace_units  = units_q;
  assign pace_active = (state_q == ST_PAUSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cond_q     <= 1'b0;
      mem_q      <= 1'b0;
      fn_q       <= '0;
      addr_q     <= '0;
      ref_q      <= '0;
      mask_q     <= '0;
      long_q     <= 1'b0;
      units_q    <= '0;
      wadr_q     <= '0;
      wdat_q     <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done       <= 1'b0;
      done_match <= 1'b0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            cond_q  <= cmd_cond;
            mem_q   <= cmd_from_mem;
            fn_q    <= cmd_func;
            addr_q  <= cmd_poll_addr;
            ref_q   <= cmd_ref;
            mask_q  <= cmd_mask;
            long_q  <= (cmd_interval >= LONG_THRESH);
            units_q <= cmd_interval[DW-1:IVL_SHIFT];
            wadr_q  <= cmd_wr_addr;
            wdat_q  <= cmd_wr_data;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: state_q <= ST_RSP;
        ST_RSP: begin
          if (ack_evt) begin
            if (cond_q) begin
              done       <= 1'b1;
              done_match <= match;
              wr_en      <= match;
              wr_addr    <= wadr_q;
              wr_data    <= wdat_q;
              state_q    <= ST_IDLE;
            end else if (poll_hit) begin
              done       <= 1'b1;
              done_match <= 1'b1;
              state_q    <= ST_IDLE;
            end else if (long_q) begin
              state_q <= ST_PAUSE;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_PAUSE: if (pace_expire) state_q <= ST_REQ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: each poll request is a single-cycle pulse
  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R2: the never code cannot yield a hit, the always code cannot miss
  p_never_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && fn_q == FN_NEVER) |-> !match);
  p_always_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && fn_q == FN_ALWAYS) |-> match);
  // R6: short interval retries at once
  p_immediate_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_now |=> rd_req);
  // R7: the end of a pause issues the next poll
  p_pause_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_active && pace_expire) |=> rd_req);
  // R8: a write only accompanies a successful completion
  p_wr_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (done && done_match));
  // R5: a wait command only finishes on a match
  p_wait_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_match) |-> cond_q);
  // R11: completion is a pulse and the block is ready right after
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
  // R10: no command is taken while a poll is outstanding
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RSP && !rd_ack) |=> !cmd_ready);
endmodule

// File: rtl/cpw_poll_wait.sv
module cpw_poll_wait #(
  parameter int DW          = 32,
  parameter int AW          = 16,
  parameter int IVL_SHIFT   = 8,
  parameter int TICK_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_cond,
  input  logic [2:0]    cmd_func,
  input  logic          cmd_from_mem,
  input  logic [AW-1:0] cmd_poll_addr,
  input  logic [DW-1:0] cmd_ref,
  input  logic [DW-1:0] cmd_mask,
  input  logic [DW-1:0] cmd_interval,
  input  logic [AW-1:0] cmd_wr_addr,
  input  logic [DW-1:0] cmd_wr_data,
  output logic          rd_req,
  output logic          rd_from_mem,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic          done_match
);
  localparam int UW = DW - IVL_SHIFT;

  logic          match;
  logic [2:0]    cmp_fn;
  logic [DW-1:0] cmp_mask;
  logic [DW-1:0] cmp_ref;
  logic          pace_start;
  logic [UW-1:0] pace_units;
  logic          pace_active;
  logic          pace_expire;

  cpw_seq #(.DW(DW), .AW(AW), .IVL_SHIFT(IVL_SHIFT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_cond(cmd_cond),
    .cmd_func(cmd_func), .cmd_from_mem(cmd_from_mem),
    .cmd_poll_addr(cmd_poll_addr), .cmd_ref(cmd_ref), .cmd_mask(cmd_mask),
    .cmd_interval(cmd_interval), .cmd_wr_addr(cmd_wr_addr),
    .cmd_wr_data(cmd_wr_data),
    .rd_req(rd_req), .rd_from_mem(rd_from_mem), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .match(match),
    .cmp_fn(cmp_fn), .cmp_mask(cmp_mask), .cmp_ref(cmp_ref),
    .pace_start(pace_start), .pace_units(pace_units),
    .pace_active(pace_active), .pace_expire(pace_expire),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .done_match(done_match)
  );

  cpw_compare #(.DW(DW)) u_cmp (
    .fn(cmp_fn), .value(rd_data), .mask(cmp_mask), .cmp_ref(cmp_ref),
    .match(match)
  );

  cpw_pacer #(.UW(UW), .TICK_CYCLES(TICK_CYCLES)) u_pace (
    .clk(clk), .rst_n(rst_n), .start(pace_start), .units(pace_units),
    .active(pace_active), .expire(pace_expire)
  );

  // R7: no poll request is issued while the pacer is counting
  p_pause_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_active && !pace_expire) |=> !rd_req);
endmodule

// File: tb/sim_cpw_poll_wait.sv
module sim_cpw_poll_wait;
  localparam int DW = 32, AW = 16, SH = 8, TK = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, cmd_cond, cmd_from_mem;
  logic [2:0] cmd_func;
  logic [AW-1:0] cmd_poll_addr, cmd_wr_addr, rd_addr, wr_addr;
  logic [DW-1:0] cmd_ref, cmd_mask, cmd_interval, cmd_wr_data, rd_data, wr_data;
  logic rd_req, rd_from_mem, rd_ack, wr_en, done, done_match;

  cpw_poll_wait #(.DW(DW), .AW(AW), .IVL_SHIFT(SH), .TICK_CYCLES(TK)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_cond(cmd_cond), .cmd_func(cmd_func), .cmd_from_mem(cmd_from_mem),
    .cmd_poll_addr(cmd_poll_addr), .cmd_ref(cmd_ref), .cmd_mask(cmd_mask),
    .cmd_interval(cmd_interval), .cmd_wr_addr(cmd_wr_addr),
    .cmd_wr_data(cmd_wr_data), .rd_req(rd_req), .rd_from_mem(rd_from_mem),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .done_match(done_match)
  );

  int total = 0, bad = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // current command as seen by the responder
  bit            in_cmd = 0, cur_cond = 0, cur_mem = 0, have_ack = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_ivl = '0;
  logic [DW-1:0] vals [0:7];
  int            nvals = 1, idx = 0, polls = 0;
  int unsigned   ack_cyc = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // independent compare model: derive order flags, then select
  function automatic bit ref_cmp(input logic [2:0] fn, input logic [DW-1:0] v,
                                 input logic [DW-1:0] m, input logic [DW-1:0] r);
    logic [DW-1:0] x;
    bit below, same;
    x = v & m;
    below = (x < r);
    same  = (x == r);
    if (fn == 3'd0) return 1'b0;
    if (fn == 3'd7) return 1'b1;
    if (fn == 3'd1) return below;
    if (fn == 3'd2) return below | same;
    if (fn == 3'd3) return same;
    if (fn == 3'd4) return !same;
    if (fn == 3'd5) return !below;
    return !below && !same;
  endfunction

  function automatic string fn_tag(input logic [2:0] fn);
    if (fn == 3'd0 || fn == 3'd1 || fn == 3'd6 || fn == 3'd7) return "R2";
    return "R3";
  endfunction

  // read responder with random latency
  initial begin
    bit skip;
    int lat;
    int unsigned gap, expgap;
    skip = 0;
    rd_ack = 1'b0;
    rd_data = '0;
    forever begin
      if (!skip) @(negedge clk);
      skip = 0;
      if (rd_req && rst_n && in_cmd) begin
        chk(rd_from_mem == cur_mem, "R4", "poll source", rd_from_mem, cur_mem);
        chk(rd_addr == cur_addr, "R4", "poll address", rd_addr, cur_addr);
        if (have_ack) begin
          gap = cyc - ack_cyc;
          expgap = (!cur_cond && cur_ivl >= 32'h100) ? 1 + (cur_ivl >> 8) * TK : 1;
          if (cur_ivl >= 32'h100)
            chk(gap == expgap, "R7", "paused poll gap", gap, expgap);
          else
            chk(gap == expgap, "R6", "immediate poll gap", gap, expgap);
        end
        polls++;
        lat = 1 + $urandom_range(0, 2);
        @(negedge clk);
        repeat (lat - 1) @(negedge clk);
        rd_data = vals[(idx < nvals) ? idx : nvals - 1];
        rd_ack = 1'b1;
        ack_cyc = cyc;
        have_ack = 1;
        idx++;
        @(negedge clk);
        rd_ack = 1'b0;
        skip = 1;
      end
    end
  end

  task automatic set_vals(input int n, input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [DW-1:0] c, input logic [DW-1:0] d);
    nvals = n;
    vals[0] = a; vals[1] = b; vals[2] = c; vals[3] = d;
  endtask

  task automatic run_cmd(input bit cond, input logic [2:0] fn, input bit mem,
                         input logic [AW-1:0] addr, input logic [DW-1:0] r,
                         input logic [DW-1:0] m, input logic [DW-1:0] ivl,
                         input logic [AW-1:0] wa, input logic [DW-1:0] wd);
    int expp, waited;
    bit expm, seen;
    expp = 1;
    expm = ref_cmp(fn, vals[0], m, r);
    if (!cond) begin
      expm = 1'b0;
      for (int k = 0; k < nvals && !expm; k++) begin
        expp = k + 1;
        expm = ref_cmp(fn, vals[k], m, r);
      end
    end
    cur_cond = cond; cur_mem = mem; cur_addr = addr; cur_ivl = ivl;
    idx = 0; polls = 0; have_ack = 0; in_cmd = 1;
    @(negedge clk);
    chk(cmd_ready, "R10", "ready while idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_cond = cond; cmd_func = fn; cmd_from_mem = mem;
    cmd_poll_addr = addr; cmd_ref = r; cmd_mask = m; cmd_interval = ivl;
    cmd_wr_addr = wa; cmd_wr_data = wd;
    @(negedge clk);
    // scramble the payload while busy; the command must not change
    cmd_cond = $urandom_range(0, 1); cmd_func = 3'($urandom);
    cmd_from_mem = $urandom_range(0, 1); cmd_poll_addr = AW'($urandom);
    cmd_ref = $urandom; cmd_mask = $urandom; cmd_interval = $urandom;
    cmd_wr_addr = AW'($urandom); cmd_wr_data = $urandom;
    chk(!cmd_ready, "R10", "not ready while busy", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    seen = 0; waited = 0;
    while (!seen && waited < 4000) begin
      if (done) seen = 1;
      else begin
        if (wr_en) chk(0, "R9", "write without done", 1, 0);
        @(negedge clk);
        waited++;
      end
    end
    chk(seen, "R5", "command completes", seen, 1);
    if (seen) begin
      if (cond) begin
        chk(done_match == expm, fn_tag(fn), "compare verdict", done_match, expm);
        if (expm) begin
          chk(wr_en, "R8", "write on match", wr_en, 1);
          chk(wr_addr == wa, "R8", "write address", wr_addr, wa);
          chk(wr_data == wd, "R8", "write data", wr_data, wd);
        end else begin
          chk(!wr_en, "R9", "no write on miss", wr_en, 0);
        end
        chk(polls == 1, "R8", "single poll", polls, 1);
      end else begin
        chk(done_match == 1'b1, "R5", "wait ends on match", done_match, 1);
        chk(!wr_en, "R5", "wait never writes", wr_en, 0);
        chk(polls == expp, "R5", "poll count", polls, expp);
      end
    end
    @(negedge clk);
    chk(!done && cmd_ready, "R11", "done pulse then ready", {done, cmd_ready}, 2'b01);
    in_cmd = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R5", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] m, r, last, hi;
    logic [2:0] fn;
    bit cond, found;
    void'($urandom(32'd4711));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_cond = 0; cmd_func = 0; cmd_from_mem = 0;
    cmd_poll_addr = '0; cmd_ref = '0; cmd_mask = '0; cmd_interval = '0;
    cmd_wr_addr = '0; cmd_wr_data = '0;
    set_vals(1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(cmd_ready && !rd_req && !wr_en && !done, "R1", "state in reset",
        {cmd_ready, rd_req, wr_en, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !rd_req && !wr_en && !done, "R1", "state after reset",
        {cmd_ready, rd_req, wr_en, done}, 4'b1000);

    // R2: never / always / strict compares at boundaries
    set_vals(1, 32'h55, 0, 0, 0);
    run_cmd(1, 3'd0, 0, 16'h0010, 32'h55, 32'hFFFF_FFFF, 0, 16'h0100, 32'hA1);
    set_vals(1, 32'h1234_5678, 0, 0, 0);
    run_cmd(1, 3'd7, 1, 16'h0011, 32'h0, 32'h0, 0, 16'h0101, 32'hA2);
    set_vals(1, 32'h40, 0, 0, 0);
    run_cmd(1, 3'd1, 0, 16'h0012, 32'h40, 32'hFF, 0, 16'h0102, 32'hA3);
    set_vals(1, 32'h3F, 0, 0, 0);
    run_cmd(1, 3'd1, 0, 16'h0012, 32'h40, 32'hFF, 0, 16'h0102, 32'hA4);
    set_vals(1, 32'h40, 0, 0, 0);
    run_cmd(1, 3'd6, 1, 16'h0013, 32'h40, 32'hFF, 0, 16'h0103, 32'hA5);
    set_vals(1, 32'h8000_0000, 0, 0, 0);
    run_cmd(1, 3'd6, 1, 16'h0013, 32'h1, 32'hFFFF_FFFF, 0, 16'h0103, 32'hA6);
    // R3: non-strict and equality codes, masked-off bits ignored
    set_vals(1, 32'hFFFF_0012, 0, 0, 0);
    run_cmd(1, 3'd3, 0, 16'h0020, 32'h12, 32'hFF, 0, 16'h0200, 32'hB1);
    run_cmd(1, 3'd4, 0, 16'h0020, 32'h12, 32'hFF, 0, 16'h0200, 32'hB2);
    run_cmd(1, 3'd2, 1, 16'h0021, 32'h12, 32'hFF, 0, 16'h0201, 32'hB3);
    run_cmd(1, 3'd5, 1, 16'h0021, 32'h12, 32'hFF, 0, 16'h0201, 32'hB4);
    run_cmd(1, 3'd2, 0, 16'h0022, 32'h11, 32'hFF, 0, 16'h0202, 32'hB5);
    run_cmd(1, 3'd5, 0, 16'h0022, 32'h13, 32'hFF, 0, 16'h0202, 32'hB6);

    // R6: interval just below threshold retries at once
    set_vals(4, 32'h1, 32'h2, 32'h3, 32'h9);
    run_cmd(0, 3'd3, 0, 16'h0030, 32'h9, 32'hF, 32'hFF, 0, 0);
    // R7: one unit at the threshold, two units above it
    set_vals(3, 32'h0, 32'h0, 32'h7, 0);
    run_cmd(0, 3'd4, 1, 16'h0031, 32'h0, 32'hF, 32'h100, 0, 0);
    set_vals(3, 32'h5, 32'h5, 32'h4, 0);
    run_cmd(0, 3'd1, 0, 16'h0032, 32'h5, 32'hFF, 32'h2A5, 0, 0);

    // R5: never code keeps polling; reset recovers
    set_vals(1, 32'h0, 0, 0, 0);
    cur_cond = 0; cur_mem = 1; cur_addr = 16'h0040; cur_ivl = 0;
    idx = 0; polls = 0; have_ack = 0; in_cmd = 1;
    @(negedge clk);
    cmd_valid = 1; cmd_cond = 0; cmd_func = 3'd0; cmd_from_mem = 1;
    cmd_poll_addr = 16'h0040; cmd_ref = 0; cmd_mask = 0; cmd_interval = 0;
    @(negedge clk);
    cmd_valid = 0;
    for (int w = 0; w < 200 && polls < 5; w++) begin
      if (done) chk(0, "R5", "never code finished", 1, 0);
      @(negedge clk);
    end
    chk(polls >= 5 && !done, "R5", "keeps polling on never", polls, 5);
    in_cmd = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cmd_ready && !rd_req, "R1", "idle under reset", {cmd_ready, rd_req}, 2'b10);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // random mix
    for (int n = 0; n < 60; n++) begin
      cond = $urandom_range(0, 1);
      if (cond) begin
        fn = 3'($urandom);
        m = $urandom | 32'hFF;
        r = $urandom_range(0, 3) == 0 ? 32'h0 : ($urandom & m);
        set_vals(1, ($urandom_range(0, 1) != 0) ? (r | ~m) : $urandom, 0, 0, 0);
        run_cmd(1, fn, $urandom_range(0, 1), AW'($urandom), r, m, $urandom,
                AW'($urandom), $urandom);
      end else begin
        fn = 3'($urandom_range(1, 7));
        m = ($urandom & 32'hFFFF_FF00) | 32'hFF;
        hi = $urandom;
        r = (hi & m & 32'hFFFF_FF00) | 32'($urandom_range(1, 254));
        last = 0; found = 0;
        for (int b = 0; b < 256 && !found; b++) begin
          last = (hi & 32'hFFFF_FF00) | 32'(b);
          found = ref_cmp(fn, last, m, r);
        end
        set_vals(4, $urandom, $urandom, $urandom, last);
        nvals = $urandom_range(1, 4);
        vals[nvals - 1] = last;
        run_cmd(0, fn, $urandom_range(0, 1), AW'($urandom), r, m,
                ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 255))
                  : (32'($urandom_range(1, 3)) << 8) | 32'($urandom_range(0, 255)),
                0, 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule